// File: doc/BRIEF.md
# Processor Supervisor with Watchdog

This block watches over a small processor system. An external comparator gives it a supply-good level, and from that level it produces a processor reset. The reset is held for as long as the supply is low. After the supply recovers, the reset is stretched for a fixed number of milliseconds so that the processor's clock oscillator has time to settle.

A software watchdog watches a strobe pin. Any change of level on that pin restarts the timeout. If the strobe stays idle for the whole timeout, the block fires a reset pulse and pulls a sticky fault line low. It then fires a further pulse after every later timeout, until the strobe moves again.

A RAM chip-enable is passed through while the supply is good. While the supply is low it is held inactive, so that no stray writes reach RAM during brownouts.

All timing comes from an internal millisecond tick. The tick divides the clock by a parameter, and every duration is a count of ticks. A bench can therefore shrink all periods. Below, D is the clock cycles per tick, R is the reset length in ticks and T is the watchdog timeout in ticks.

Top module: `proc_supervisor`

## Requirements
- R1: Within 3 clock cycles of `supply_ok` going low, `reset_n` is 0, and it stays 0 while `supply_ok` stays low.
- R2: After `supply_ok` rises and stays high, `reset_n` returns to 1 exactly 2 + D·R clock edges later.
- R3: `reset_hi` is always the complement of `reset_n`.
- R4: With the watchdog enabled and the strobe idle, a reset pulse starts D·T cycles after the point where the timeout was last restarted. The pulse lasts D·R cycles. The restart points are the end of a reset and the cycle that takes in a strobe edge.
- R5: A rising edge and a falling edge on `wd_strobe` both restart the timeout. The next timeout reset falls exactly 3 + D·T edges after the strobe change.
- R6: While the strobe stays idle, a new reset pulse starts D·T cycles after each earlier pulse ends.
- R7: `wd_fault_n` falls in the same cycle that a timeout reset starts. It stays 0 through any repeated pulses. It returns to 1 exactly 3 edges after the next strobe change, even if that change comes during a reset pulse.
- R8: While `wd_enable` is 0, no timeout reset occurs and `wd_fault_n` is 1 from the first edge after disabling.
- R9: `ce_out_n` equals `ce_in_n` while the synchronized supply is good. It is 1 whenever the synchronized supply is low. A supply change reaches this output within 3 edges.
- R10: While `por_n` is low, the outputs are `reset_n`=0, `reset_hi`=1, `wd_fault_n`=1 and `ce_out_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on clear, active low, sampled on the clock |
| supply_ok | input | 1 | Supply-good flag from the external comparator (asynchronous) |
| wd_strobe | input | 1 | Watchdog strobe; either edge services the timer (asynchronous) |
| wd_enable | input | 1 | 1 enables the watchdog |
| ce_in_n | input | 1 | RAM chip-enable from the processor, active low |
| reset_n | output | 1 | Processor reset, active low |
| reset_hi | output | 1 | Processor reset, active high |
| wd_fault_n | output | 1 | Sticky watchdog fault, active low |
| ce_out_n | output | 1 | Gated RAM chip-enable, active low |

## Verification
Results arrive with different delays:

- `supply_ok` and `wd_strobe` each pass two synchronizer flops. A supply change therefore reaches `ce_out_n` and the reset logic within 3 edges.
- Reset release follows 2 + D·R edges after the supply rises.
- A strobe edge clears the fault after 3 edges.
- The next timeout reset comes exactly 3 + D·T edges after the strobe change.

The bench drives inputs just after a rising edge and samples just after the n-th following edge. The timing checks sample one cycle before and one cycle after each expected change, so an off-by-one shows up. The "stays" cases are checked on every cycle of their window rather than at one point.

// File: rtl/sup_pkg.sv
// Package: shared helpers for the processor supervisor.
// Assumes: counters are sized from a positive terminal count.
package sup_pkg;

    // Width needed to hold values 0..n-1, never less than one bit.
    function automatic int cnt_w(input int n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sup_sync.sv
// Module: sup_sync
// Double-flop synchronizer for W independent asynchronous inputs.
// Assumes: each bit is a slow level; bits are not related to each other.
module sup_sync #(
    parameter int W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        // Two-stage capture of bit i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta <= RST_VAL[i];
                q[i] <= RST_VAL[i];
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end
endmodule

// File: rtl/sup_tick.sv
// Module: sup_tick
// Prescaler. Emits a one-cycle tick every DIV clocks.
// Assumes: clr restarts the phase, so the first tick comes DIV cycles after clr.
module sup_tick #(
    parameter int DIV = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    import sup_pkg::*;
    localparam int CW = cnt_w(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] pcnt;

    assign tick = (pcnt == LAST);

    // Free-running divider with synchronous restart.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || tick) pcnt <= '0;
        else                       pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/sup_hold_timer.sv
// Module: sup_hold_timer
// Keeps the reset asserted while the supply is low or a restart is requested.
// It then releases after LEN ticks.
// Assumes: tick is a one-cycle strobe whose phase restarts with each restart.
module sup_hold_timer #(
    parameter int LEN = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_s,
    input  logic restart,
    input  logic tick,
    output logic hold
);
    import sup_pkg::*;
    localparam int CW = cnt_w(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    // Reset stretch counter: restart on low supply or trip, count ticks while held.
    always_ff @(posedge clk) begin
        if (!rst_n || !supply_s || restart) begin
            hold <= 1'b1;
            cnt  <= '0;
        end else if (hold && tick) begin
            if (cnt == LAST) begin
                hold <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sup_watchdog.sv
// Module: sup_watchdog
// Timeout counter and sticky fault flag.
// Assumes: stb_edge is a synchronized one-cycle pulse; the count is frozen at zero while hold is high.
module sup_watchdog #(
    parameter int TIMEOUT = 1600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic stb_edge,
    input  logic hold,
    input  logic tick,
    output logic trip,
    output logic fault_n
);
    import sup_pkg::*;
    localparam int CW = cnt_w(TIMEOUT);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;
    logic          run;

    assign run  = enable && !hold && !stb_edge;
    assign trip = run && tick && (cnt == LAST);

    // Timeout counter: cleared when not running, wraps on trip.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= trip ? '0 : cnt + 1'b1;
    end

    // Sticky fault: set by a trip, cleared by a strobe edge or by disabling.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || stb_edge) fault_n <= 1'b1;
        else if (trip)                     fault_n <= 1'b0;
    end
endmodule

// File: rtl/proc_supervisor.sv
// Module: proc_supervisor (top)
// Supply-driven reset stretcher, watchdog with repeating reset pulses, and RAM chip-enable gate.
// Assumes: supply_ok and wd_strobe are asynchronous; wd_enable and ce_in_n are synchronous to clk.
module proc_supervisor #(
    parameter int TICK_CYCLES = 200000,
    parameter int RST_TICKS   = 50,
    parameter int WD_TICKS    = 1600
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok,
    input  logic wd_strobe,
    input  logic wd_enable,
    input  logic ce_in_n,
    output logic reset_n,
    output logic reset_hi,
    output logic wd_fault_n,
    output logic ce_out_n
);
    logic [1:0] sync_q;
    logic       sup_s;
    logic       stb_s;
    logic       stb_q;
    logic       stb_edge;
    logic       tick;
    logic       tick_clr;
    logic       hold;
    logic       trip;

    sup_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d     ({wd_strobe, supply_ok}),
        .q     (sync_q)
    );
    assign sup_s = sync_q[0];
    assign stb_s = sync_q[1];

    // Previous strobe level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!por_n) stb_q <= 1'b0;
        else        stb_q <= stb_s;
    end
    assign stb_edge = stb_s ^ stb_q;

    // The tick phase restarts on every event that starts a timed interval.
    assign tick_clr = !sup_s || trip || (stb_edge && !hold);

    sup_tick #(.DIV(TICK_CYCLES)) u_tick (
        .clk   (clk),
        .rst_n (por_n),
        .clr   (tick_clr),
        .tick  (tick)
    );

    sup_hold_timer #(.LEN(RST_TICKS)) u_hold (
        .clk      (clk),
        .rst_n    (por_n),
        .supply_s (sup_s),
        .restart  (trip),
        .tick     (tick),
        .hold     (hold)
    );

    sup_watchdog #(.TIMEOUT(WD_TICKS)) u_wd (
        .clk      (clk),
        .rst_n    (por_n),
        .enable   (wd_enable),
        .stb_edge (stb_edge),
        .hold     (hold),
        .tick     (tick),
        .trip     (trip),
        .fault_n  (wd_fault_n)
    );

    assign reset_n  = !hold;
    assign reset_hi = hold;
    assign ce_out_n = ce_in_n || !sup_s;
endmodule

// File: rtl/sup_checker.sv
// Module: sup_checker
// Temporal properties of proc_supervisor, attached with bind.
// Assumes: por_n is low from time zero.
module sup_checker (
    input logic clk,
    input logic por_n,
    input logic supply_s,
    input logic stb_edge,
    input logic wd_enable,
    input logic reset_n,
    input logic wd_fault_n,
    input logic ce_out_n
);
    // R1: a low synchronized supply asserts reset on the next cycle.
    a_r1_low_supply_resets: assert property (@(posedge clk) disable iff (!por_n)
        !supply_s |=> !reset_n);

    // R2: a reset release only happens with the supply good now and one cycle earlier.
    a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!por_n)
        $rose(reset_n) |-> (supply_s && $past(supply_s)));

    // R4: the fault falls only together with the start of a reset pulse.
    a_r4_fault_with_reset: assert property (@(posedge clk) disable iff (!por_n)
        $fell(wd_fault_n) |-> $fell(reset_n));

    // R7: the fault stays low until a strobe edge or a disable.
    a_r7_fault_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (!wd_fault_n && wd_enable && !stb_edge) |=> !wd_fault_n);

    // R8: a disabled watchdog shows no fault.
    a_r8_disabled_no_fault: assert property (@(posedge clk) disable iff (!por_n)
        !wd_enable |=> wd_fault_n);

    // R9: chip-enable is inactive while the supply is low.
    a_r9_ce_blocked: assert property (@(posedge clk) disable iff (!por_n)
        !supply_s |-> ce_out_n);
endmodule

bind proc_supervisor sup_checker u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .supply_s   (sup_s),
    .stb_edge   (stb_edge),
    .wd_enable  (wd_enable),
    .reset_n    (reset_n),
    .wd_fault_n (wd_fault_n),
    .ce_out_n   (ce_out_n)
);

// File: tb/proc_supervisor_test.sv
// Bench: proc_supervisor with short timing (D=4, R=5, T=12).
module proc_supervisor_test;
    localparam int D  = 4;
    localparam int RT = 5;
    localparam int WT = 12;
    localparam int RST_CYC = D * RT;
    localparam int WD_CYC  = D * WT;

    // Vector fields: {supply_ok, ce_in_n, expected ce_out_n, expected reset low}
    localparam int NV = 6;
    localparam logic [3:0] VEC [NV] = '{
        4'b1000, 4'b1110, 4'b0011, 4'b0111, 4'b1111, 4'b1001
    };

    logic clk = 1'b0;
    logic por_n, supply_ok, wd_strobe, wd_enable, ce_in_n;
    logic reset_n, reset_hi, wd_fault_n, ce_out_n;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    proc_supervisor #(.TICK_CYCLES(D), .RST_TICKS(RT), .WD_TICKS(WT)) uut (
        .clk        (clk),
        .por_n      (por_n),
        .supply_ok  (supply_ok),
        .wd_strobe  (wd_strobe),
        .wd_enable  (wd_enable),
        .ce_in_n    (ce_in_n),
        .reset_n    (reset_n),
        .reset_hi   (reset_hi),
        .wd_fault_n (wd_fault_n),
        .ce_out_n   (ce_out_n)
    );

    // Advance n rising edges, then settle 1 ns past the edge.
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Require reset_n high and reset_hi low on every one of n cycles.
    task automatic stay_released(input string req, input int n);
        bit bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            cyc(1);
            if (reset_n !== 1'b1 || reset_hi !== 1'b0) bad = 1'b1;
        end
        check(req, bad, 1'b0);
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; supply_ok = 1'b0; wd_strobe = 1'b0; wd_enable = 1'b0; ce_in_n = 1'b0;
        cyc(3);
        check("R10 reset_n", reset_n, 1'b0);
        check("R10 reset_hi", reset_hi, 1'b1);
        check("R10 wd_fault_n", wd_fault_n, 1'b1);
        check("R10 ce_out_n", ce_out_n, 1'b1);

        por_n = 1'b1;
        cyc(5);
        check("R1 low supply", reset_n, 1'b0);
        supply_ok = 1'b1;
        cyc(2 + RST_CYC - 1);
        check("R2 before release", reset_n, 1'b0);
        cyc(1);
        check("R2 at release", reset_n, 1'b1);
        check("R3 complement", reset_hi, 1'b0);

        // Table walk: chip-enable gating and reset versus supply.
        for (int v = 0; v < NV; v++) begin
            supply_ok = VEC[v][3];
            ce_in_n   = VEC[v][2];
            cyc(3);
            check("R9 ce_out_n", ce_out_n, VEC[v][1]);
            check("R1 reset low", !reset_n, VEC[v][0]);
            check("R3 complement", reset_hi, !reset_n);
        end
        cyc(RST_CYC + 10);
        check("R2 recovered", reset_n, 1'b1);

        // R8: disabled watchdog never trips.
        stay_released("R8 disabled", 3 * WD_CYC);
        check("R8 fault high", wd_fault_n, 1'b1);

        // R4: enable and restart with a rising strobe edge.
        wd_enable = 1'b1; wd_strobe = 1'b1;
        stay_released("R4 before timeout", 2 + WD_CYC);
        cyc(1);
        check("R4 timeout reset", reset_n, 1'b0);
        check("R7 fault on timeout", wd_fault_n, 1'b0);
        cyc(RST_CYC - 1);
        check("R4 pulse held", reset_n, 1'b0);
        cyc(1);
        check("R4 pulse end", reset_n, 1'b1);
        check("R7 fault kept", wd_fault_n, 1'b0);

        // R6: the pulse repeats while the strobe is idle.
        cyc(WD_CYC - 1);
        check("R6 before repeat", reset_n, 1'b1);
        cyc(1);
        check("R6 repeat pulse", reset_n, 1'b0);
        check("R7 fault through repeat", wd_fault_n, 1'b0);

        // R7: a strobe edge during the pulse clears the fault.
        wd_strobe = 1'b0;
        cyc(2);
        check("R7 fault before clear", wd_fault_n, 1'b0);
        cyc(1);
        check("R7 fault cleared", wd_fault_n, 1'b1);
        cyc(RST_CYC - 4);
        check("R4 repeat pulse held", reset_n, 1'b0);
        cyc(1);
        check("R4 repeat pulse end", reset_n, 1'b1);

        // R5: a rising edge in the middle of the window restarts it.
        cyc(30);
        wd_strobe = 1'b1;
        stay_released("R5 rising restart", 2 + WD_CYC);
        cyc(1);
        check("R5 rising timeout", reset_n, 1'b0);
        cyc(RST_CYC);
        check("R4 pulse end", reset_n, 1'b1);

        // R5: a falling edge restarts it as well.
        cyc(30);
        wd_strobe = 1'b0;
        stay_released("R5 falling restart", 2 + WD_CYC);
        cyc(1);
        check("R5 falling timeout", reset_n, 1'b0);
        check("R7 fault again", wd_fault_n, 1'b0);

        // R8: disabling clears the fault and stops further pulses.
        wd_enable = 1'b0;
        cyc(1);
        check("R8 fault released", wd_fault_n, 1'b1);
        cyc(RST_CYC + 5);
        stay_released("R8 no more pulses", 3 * WD_CYC);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule